// File: doc/BRIEF.md
# Delayed Parity Checker with Held Error Flag

This block watches the command word entering a registered command buffer and checks it against a parity bit that the controller sends one clock later. On every rising edge it samples a 28-bit data word and four active-low chip selects. Parity is formed over a fixed group of 22 of the data bits. A word is checked only if at least one chip select was low in the cycle it was sampled. One clock later the parity input is sampled and compared with the stored parity of that word. A mismatch drives the active-low error output low.

The error output is registered, so it falls one cycle after the compare. Once low it stays low for at least two cycles. A further mismatch during that time restarts the hold. The output returns high by itself when the hold runs out with no new mismatch. It goes high at once, without waiting for a clock, whenever reset is asserted. The first word sampled after reset is released is never checked, so stray levels on the inputs during start-up cannot raise a false error.

A word is accepted on every clock; there is no back-pressure and no ready signal. The chip selects act as the valid qualifier for the word sampled in the same cycle. The parity input is always taken to belong to the word sampled one edge earlier.

Top module: `lagpar_checker`

## Requirements
- R1: While rst_n is low, err_n is 1. Asserting rst_n forces err_n high at once, without waiting for a clock edge.
- R2: Parity covers data_in bits 0 through 21. Bits 22 through 27 have no effect on the result. Bit 21 is covered.
- R3: Parity is even. A word sampled at edge n is flagged when the XOR of its covered bits and par_in sampled at edge n+1 equals 1.
- R4: For a flagged word sampled at edge n, err_n goes low right after edge n+2 and is still high between edges n+1 and n+2.
- R5: A word sampled while all four cs_n bits are 1 is never flagged, whatever the parity.
- R6: cs_n[2] or cs_n[3] low on its own qualifies a word exactly as cs_n[0] or cs_n[1] low does. Any single low chip-select bit is enough.
- R7: After a single mismatch, err_n stays low for exactly 2 cycles and then returns to 1.
- R8: A mismatch that arrives while err_n is held low restarts the 2-cycle hold, counted from its own fall time.
- R9: The word sampled at the first rising edge after rst_n is released is not checked.
- R10: Every qualified word is checked, including back-to-back words. A stream of words with correct parity leaves err_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 28 | Command word sampled every cycle |
| par_in | input | 1 | Even parity of the covered bits of the word sampled one edge earlier |
| cs_n | input | 4 | Active-low chip selects; any low bit qualifies the word of that cycle |
| err_n | output | 1 | Active-low held parity error flag |

## Verification
The checker is driven with streams of correct-parity words whose covered bits have zero, odd, alternating and full weight, spread across every chip select. A correct design stays silent on all of them. The same stream also shows that no pipeline bubble skips a word. Single wrong-parity words, with both an even and an odd covered weight, pin the exact fall cycle and the two-cycle hold. Wrong parity placed only on the uncovered bits, or on bit 21, shows where the covered range ends. Paired errors one and two cycles apart separate a restarting hold from a non-restarting one. A bad word sent with no chip select, or together with reset release, shows the gating and the start-up blanking.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned LPC_DATA_W     = 28;
  localparam int unsigned LPC_COVER_LSB  = 0;
  localparam int unsigned LPC_COVER_BITS = 22;
  localparam int unsigned LPC_CS_W       = 4;
  localparam int unsigned LPC_HOLD       = 2;

  // width of a counter that must hold the value n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lpc_par_tree.sv
module lpc_par_tree #(
  parameter int unsigned W    = 28,
  parameter int unsigned LSB  = 0,
  parameter int unsigned BITS = 22
) (
  input  logic [W-1:0] data,
  output logic         par
);
  localparam int unsigned LEVELS = (W < 2) ? 1 : $clog2(W);
  localparam int unsigned SPAN   = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned N = SPAN >> l;
    logic [N-1:0] v;
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_bit
        if (i < W && i >= LSB && i < LSB + BITS) begin : g_in
          assign v[i] = data[i];
        end else if (i < W) begin : g_off
          assign v[i] = data[i] & 1'b0;
        end else begin : g_pad
          assign v[i] = 1'b0;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < N; i++) begin : g_xor
        assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
      end
    end
  end

  assign par = g_lvl[LEVELS].v[0];
endmodule

// File: rtl/lpc_cs_qual.sv
module lpc_cs_qual #(
  parameter int unsigned CS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CS_W-1:0] cs_n,
  output logic            qual
);
  logic blank_q;
  logic any_sel;

  // first edge after reset release is blanked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b1;
    else        blank_q <= 1'b0;
  end

  assign any_sel = ~&cs_n;
  assign qual    = any_sel & ~blank_q;
endmodule

// File: rtl/lpc_align.sv
module lpc_align (
  input  logic clk,
  input  logic rst_n,
  input  logic dpar,
  input  logic qual,
  input  logic par_in,
  output logic mis_q
);
  logic dpar_q;
  logic qual_q;

  // stage 1 keeps one bit of parity, not the word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpar_q <= 1'b0;
      qual_q <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      dpar_q <= dpar;
      qual_q <= qual;
      mis_q  <= qual_q & (dpar_q ^ par_in);
    end
  end
endmodule

// File: rtl/lpc_stretch.sv
module lpc_stretch #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mis,
  output logic err_n
);
  localparam int unsigned CW = lpc_pkg::cnt_w(HOLD);

  logic          err_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      left_q <= '0;
    end else if (mis) begin
      err_q  <= 1'b1;
      left_q <= CW'(HOLD - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      err_q  <= 1'b0;
    end
  end

  assign err_n = ~err_q;

  // run length of the low phase, for the hold check
  logic [CW-1:0] lowrun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lowrun_q <= '0;
    else if (err_n)                 lowrun_q <= '0;
    else if (lowrun_q != CW'(HOLD)) lowrun_q <= lowrun_q + 1'b1;
  end

  assert_hold_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> (lowrun_q >= CW'(HOLD)));
endmodule

// File: rtl/lagpar_checker.sv
module lagpar_checker #(
  parameter int unsigned DATA_W     = lpc_pkg::LPC_DATA_W,
  parameter int unsigned COVER_LSB  = lpc_pkg::LPC_COVER_LSB,
  parameter int unsigned COVER_BITS = lpc_pkg::LPC_COVER_BITS,
  parameter int unsigned CS_W       = lpc_pkg::LPC_CS_W,
  parameter int unsigned HOLD_CYC   = lpc_pkg::LPC_HOLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_in,
  input  logic [CS_W-1:0]   cs_n,
  output logic              err_n
);
  logic dpar;
  logic qual;
  logic mis_q;

  lpc_par_tree #(.W(DATA_W), .LSB(COVER_LSB), .BITS(COVER_BITS)) u_tree (
    .data (data_in),
    .par  (dpar)
  );

  lpc_cs_qual #(.CS_W(CS_W)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .qual  (qual)
  );

  lpc_align u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .dpar   (dpar),
    .qual   (qual),
    .par_in (par_in),
    .mis_q  (mis_q)
  );

  lpc_stretch #(.HOLD(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .mis   (mis_q),
    .err_n (err_n)
  );

  // port-level checks: word at edge n, parity at n+1, flag seen at n+3
  logic       chk_sel;
  logic       chk_dpar;
  logic [2:0] seen_q;

  assign chk_sel  = ~&cs_n;
  assign chk_dpar = ^data_in[COVER_LSB +: COVER_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seen_q <= '0;
    else if (seen_q != 3'd4) seen_q <= seen_q + 3'd1;
  end

  assert_blank_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != 3'd4) |-> err_n);

  assert_flag_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_n) && seen_q == 3'd4) |-> ($past(chk_dpar, 3) != $past(par_in, 2)));

  assert_unselected_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_n) && seen_q == 3'd4) |-> $past(chk_sel, 3));

  assert_bad_word_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd4 && $past(chk_sel, 3) && ($past(chk_dpar, 3) != $past(par_in, 2)))
      |-> !err_n);
endmodule

// File: tb/sim_lagpar_checker.sv
module sim_lagpar_checker;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] data_in = '0;
  logic        par_in = 1'b0;
  logic [3:0]  cs_n = 4'hF;
  logic        err_n;

  always #(CLK_P/2) clk = ~clk;

  lagpar_checker u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_in (data_in),
    .par_in  (par_in),
    .cs_n    (cs_n),
    .err_n   (err_n)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic obs [0:63];
  int   idx = 0;
  logic next_par = 1'b0;

  function automatic logic cpar(input logic [27:0] d);
    return ^d[21:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_obs(input int i, input logic e, input string req);
    check(obs[i] === e, $sformatf("%s cycle %0d", req, i), int'(obs[i]), int'(e));
  endtask

  // records err_n before driving; word sent at call i shows at obs[i+3]
  task automatic send(input logic [27:0] d, input logic [3:0] cs, input bit flip);
    @(negedge clk);
    if (idx < 64) obs[idx] = err_n;
    idx++;
    data_in  = d;
    cs_n     = cs;
    par_in   = next_par;
    next_par = cpar(d) ^ flip;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) send(28'h0, 4'hF, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; data_in = '0; cs_n = 4'hF; par_in = 1'b0; next_par = 1'b0;
    #1 check(err_n === 1'b1, "R1 reset level", int'(err_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idx = 0;
  endtask

  task automatic t_good_stream();   // R10, R3
    do_reset();
    send(28'h0000000, 4'hE, 1'b0);
    send(28'h03FFFFF, 4'hD, 1'b0);
    send(28'h0000001, 4'hB, 1'b0);
    send(28'hAAAAAAA, 4'h7, 1'b0);
    send(28'h0155555, 4'h0, 1'b0);
    idle(6);
    for (int i = 3; i <= 10; i++) expect_obs(i, 1'b1, "R10 good stream");
  endtask

  task automatic t_single_error();  // R3, R4, R7
    do_reset();
    send(28'h0000005, 4'hE, 1'b1);
    idle(6);
    expect_obs(2, 1'b1, "R4 not early");
    expect_obs(3, 1'b0, "R3 even-weight mismatch");
    expect_obs(4, 1'b0, "R7 held");
    expect_obs(5, 1'b1, "R7 released");
    send(28'h0000001, 4'hD, 1'b1);
    idle(6);
    expect_obs(9,  1'b1, "R4 not early");
    expect_obs(10, 1'b0, "R3 odd-weight mismatch");
    expect_obs(11, 1'b0, "R7 held");
    expect_obs(12, 1'b1, "R7 released");
  endtask

  task automatic t_cover_range();   // R2
    do_reset();
    send(28'h0400000, 4'hE, 1'b0);
    idle(2);
    send(28'h8000000, 4'hE, 1'b0);
    idle(2);
    send(28'h0200000, 4'hE, 1'b0);
    idle(6);
    for (int i = 0; i <= 11; i++) expect_obs(i, 1'b1, "R2 upper bits ignored");
    send(28'h0200000, 4'hE, 1'b1);
    idle(6);
    expect_obs(16, 1'b0, "R2 bit 21 covered");
  endtask

  task automatic t_selects();       // R5, R6
    do_reset();
    send(28'h0000005, 4'hF, 1'b1);
    idle(6);
    expect_obs(3, 1'b1, "R5 unselected");
    expect_obs(4, 1'b1, "R5 unselected");
    send(28'h0000005, 4'hB, 1'b1);
    idle(6);
    expect_obs(10, 1'b0, "R6 cs2 alone");
    send(28'h0000005, 4'h7, 1'b1);
    idle(6);
    expect_obs(17, 1'b0, "R6 cs3 alone");
    send(28'h0000005, 4'hD, 1'b1);
    idle(6);
    expect_obs(24, 1'b0, "R5 cs1 alone");
  endtask

  task automatic t_restart();       // R8
    do_reset();
    send(28'h0000005, 4'hE, 1'b1);
    send(28'h0000006, 4'hE, 1'b1);
    idle(7);
    expect_obs(3, 1'b0, "R8 first");
    expect_obs(4, 1'b0, "R8 restarted");
    expect_obs(5, 1'b0, "R8 restarted");
    expect_obs(6, 1'b1, "R8 end");
    send(28'h0000005, 4'hE, 1'b1);
    idle(1);
    send(28'h0000005, 4'hE, 1'b1);
    idle(7);
    for (int i = 12; i <= 15; i++) expect_obs(i, 1'b0, "R8 gap-one restart");
    expect_obs(16, 1'b1, "R8 end");
  endtask

  task automatic t_blank();         // R9
    @(negedge clk);
    rst_n = 1'b0; data_in = '0; cs_n = 4'hF; par_in = 1'b0; next_par = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; data_in = 28'h0000001; cs_n = 4'hE; next_par = 1'b0;
    idx = 0;
    idle(6);
    for (int i = 0; i <= 5; i++) expect_obs(i, 1'b1, "R9 first word unchecked");
    send(28'h0000001, 4'hE, 1'b1);
    idle(5);
    expect_obs(9, 1'b0, "R9 later word checked");
  endtask

  task automatic t_async_reset();   // R1
    do_reset();
    send(28'h0000005, 4'hE, 1'b1);
    idle(3);
    check(err_n === 1'b0, "R1 precondition low", int'(err_n), 0);
    #2 rst_n = 1'b0;
    #1 check(err_n === 1'b1, "R1 immediate release", int'(err_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_good_stream();
    t_single_error();
    t_cover_range();
    t_selects();
    t_restart();
    t_blank();
    t_async_reset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule